// File: doc/BRIEF.md
# Four-Mode Built-In Logic Block Observer Register

This block is a bank of flip-flops that takes one of four roles, chosen by a two-bit mode code. It can be an ordinary parallel register, a serial shift chain, a self-running linear-feedback pattern source, or a multiple-input signature compactor. One such register can drive stimulus into a piece of logic while a second one compacts that logic's response. The roles are then exchanged to test the next piece of logic.

Stage 0 is the head of the chain and stage `WIDTH-1` is its tail. The feedback bit is the XOR of the stages selected by the `TAPS` mask, and it enters stage 0. The default mask describes the primitive polynomial x^8 + x^6 + x^5 + x^4 + 1. Setting every bit of `TAPS` gives the all-terms polynomial 1 + x + ... + x^n instead. The usual way to set the register to a known state is to shift zeros through it. A pattern run must be seeded by shifting in a non-zero value first.

Top module: `bilbo_reg`

## Requirements
- R1: While the reset input is low, and until the first clock edge after its synchronised release, `par_out` is all zeros and `scan_out` is 0.
- R2: In shift mode (`mode_b1`=0, `mode_b2`=0), every clock edge loads `scan_in` into stage 0 and stage i-1 into stage i. `scan_out` always shows stage `WIDTH-1`, in every mode.
- R3: Shifting `WIDTH` zeros in shift mode clears the register from any starting state.
- R4: In load mode (`mode_b1`=1, `mode_b2`=0), every clock edge copies `par_in` into `par_out`.
- R5: In generator mode (`mode_b1`=0, `mode_b2`=1), every clock edge loads the XOR of the stages selected by `TAPS` into stage 0 and stage i-1 into stage i. `par_in` has no effect on the sequence.
- R6: In generator mode, an all-zero state stays all zero.
- R7: With the default `TAPS`, generator mode returns to its non-zero seed after exactly 2^`WIDTH`-1 edges and never reaches zero along the way.
- R8: In compactor mode (`mode_b1`=1, `mode_b2`=1), stage 0 loads the feedback bit XOR `par_in[0]`. Stage i loads stage i-1 XOR `par_in[i]`. A single-bit change in one input word changes the final signature.
- R9: A change of mode code takes effect at the next clock edge. That edge already uses the new mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| mode_b1 | input | 1 | Upper mode bit |
| mode_b2 | input | 1 | Lower mode bit |
| par_in | input | WIDTH | Parallel data input |
| par_out | output | WIDTH | Register contents |
| scan_in | input | 1 | Serial input to stage 0 |
| scan_out | output | 1 | Serial output from stage WIDTH-1 |

## Verification
Embedded assertions check the per-edge update of every mode on every cycle. These cover the shift chain, parallel load, the per-stage XOR of the compactor, and the zero lock and non-zero preservation of the generator. Only the bench scenarios can show the properties that span many cycles. These are the full 2^`WIDTH`-1 period, clearing by a run of zeros, the independence of the generated sequence from `par_in`, and the change in signature caused by a single flipped input bit. The reset values are also checked only by the bench.

// File: rtl/bilbo_pkg.sv
package bilbo_pkg;
  typedef enum logic [1:0] {
    MODE_SHIFT   = 2'b00,
    MODE_GEN     = 2'b01,
    MODE_LOAD    = 2'b10,
    MODE_COMPACT = 2'b11
  } bilbo_mode_e;
endpackage

// File: rtl/bilbo_rst_sync.sv
module bilbo_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/bilbo_feedback.sv
module bilbo_feedback #(
  parameter int               WIDTH = 8,
  parameter logic [WIDTH-1:0] TAPS  = 8'b1011_1000
) (
  input  logic [WIDTH-1:0] state,
  output logic             fb
);
  always_comb begin
    fb = ^(state & TAPS);
  end
endmodule

// File: rtl/bilbo_next.sv
module bilbo_next
  import bilbo_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  bilbo_mode_e      mode,
  input  logic [WIDTH-1:0] state,
  input  logic [WIDTH-1:0] par_in,
  input  logic             scan_in,
  input  logic             fb,
  output logic [WIDTH-1:0] nxt
);
  logic [WIDTH-1:0] chain_src;

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_stage
      if (i == 0) begin : g_head
        always_comb begin
          chain_src[i] = (mode == MODE_SHIFT) ? scan_in : fb;
        end
      end else begin : g_body
        always_comb begin
          chain_src[i] = state[i-1];
        end
      end

      always_comb begin
        unique case (mode)
          MODE_SHIFT:   nxt[i] = chain_src[i];
          MODE_GEN:     nxt[i] = chain_src[i];
          MODE_LOAD:    nxt[i] = par_in[i];
          MODE_COMPACT: nxt[i] = chain_src[i] ^ par_in[i];
          default:      nxt[i] = state[i];
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/bilbo_reg.sv
module bilbo_reg
  import bilbo_pkg::*;
#(
  parameter int               WIDTH = 8,
  parameter logic [WIDTH-1:0] TAPS  = 8'b1011_1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_b1,
  input  logic             mode_b2,
  input  logic [WIDTH-1:0] par_in,
  output logic [WIDTH-1:0] par_out,
  input  logic             scan_in,
  output logic             scan_out
);
  localparam int TAIL = WIDTH - 1;

  logic             rst_sync_n;
  bilbo_mode_e      mode;
  logic             fb;
  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] state_d;

  assign mode = bilbo_mode_e'({mode_b1, mode_b2});

  bilbo_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bilbo_feedback #(.WIDTH(WIDTH), .TAPS(TAPS)) u_feedback (
    .state (state_q),
    .fb    (fb)
  );

  bilbo_next #(.WIDTH(WIDTH)) u_next (
    .mode    (mode),
    .state   (state_q),
    .par_in  (par_in),
    .scan_in (scan_in),
    .fb      (fb),
    .nxt     (state_d)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) state_q <= '0;
    else             state_q <= state_d;
  end

  assign par_out  = state_q;
  assign scan_out = state_q[TAIL];

  AST_SHIFT_CHAIN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode == MODE_SHIFT) |=> (par_out == {$past(par_out[WIDTH-2:0]), $past(scan_in)})); // R2

  AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode == MODE_LOAD) |=> (par_out == $past(par_in))); // R4

  AST_GEN_SHIFT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode == MODE_GEN) |=> (par_out[WIDTH-1:1] == $past(par_out[WIDTH-2:0]))); // R5

  AST_GEN_ZERO_LOCK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((mode == MODE_GEN) && (par_out == '0)) |=> (par_out == '0)); // R6

  AST_GEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((mode == MODE_GEN) && (par_out != '0)) |=> (par_out != '0)); // R7

  AST_COMPACT_XOR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode == MODE_COMPACT) |=>
      (par_out[WIDTH-1:1] == ($past(par_out[WIDTH-2:0]) ^ $past(par_in[WIDTH-1:1])))); // R8
endmodule

// File: tb/bilbo_reg_bench.sv
module bilbo_reg_bench;
  localparam int         W    = 8;
  localparam logic [7:0] TAPS = 8'b1011_1000;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         b1, b2;
  logic [W-1:0] pin;
  logic [W-1:0] pout;
  logic         si, so;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  bilbo_reg #(.WIDTH(W), .TAPS(TAPS)) u_bilbo_reg (
    .clk(clk), .rst_n(rst_n), .mode_b1(b1), .mode_b2(b2),
    .par_in(pin), .par_out(pout), .scan_in(si), .scan_out(so)
  );

  function automatic logic [W-1:0] model(input logic [1:0] m, input logic [W-1:0] q,
                                         input logic [W-1:0] d, input logic s);
    logic f;
    f = ^(q & TAPS);
    case (m)
      2'b00:   model = {q[W-2:0], s};
      2'b01:   model = {q[W-2:0], f};
      2'b10:   model = d;
      default: model = {q[W-2:0], f} ^ d;
    endcase
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic set_mode(input logic [1:0] m);
    {b1, b2} = m;
  endtask

  task automatic scan_load(input logic [W-1:0] v);
    set_mode(2'b00);
    for (int k = W - 1; k >= 0; k--) begin
      si = v[k];
      step();
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; set_mode(2'b10); pin = 8'hFF; si = 1'b1;
    step(); step();
    chk("R1 par_out in reset", pout, '0);
    chk("R1 scan_out in reset", {7'd0, so}, '0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 par_out after release", pout, '0);
    step(); step();
  endtask

  task automatic t_load();
    set_mode(2'b10);
    pin = 8'hA5; step(); chk("R4 load A5", pout, 8'hA5);
    pin = 8'h3C; step(); chk("R4 load 3C", pout, 8'h3C);
    chk("R2 scan_out is tail", {7'd0, so}, 8'h00);
  endtask

  task automatic t_scan();
    logic [W-1:0] old;
    old = pout;
    set_mode(2'b00); si = 1'b1; step();
    chk("R2 first shift", pout, {old[W-2:0], 1'b1});
    chk("R2 scan_out follows tail", {7'd0, so}, {7'd0, old[W-2]});
    scan_load(8'hC5);
    chk("R2 scan load C5", pout, 8'hC5);
    scan_load(8'h00);
    chk("R3 zeros clear", pout, 8'h00);
  endtask

  task automatic t_gen();
    logic [W-1:0] seq_a [20];
    logic [W-1:0] exp_q;
    bit mism;
    scan_load(8'h5A);
    set_mode(2'b01); pin = 8'h00; exp_q = 8'h5A;
    for (int k = 0; k < 20; k++) begin
      step(); exp_q = model(2'b01, exp_q, pin, 1'b0); seq_a[k] = pout;
    end
    chk("R5 generator sequence", pout, exp_q);
    scan_load(8'h5A);
    set_mode(2'b01); mism = 0;
    for (int k = 0; k < 20; k++) begin
      pin = 8'(k * 37 + 1); step();
      if (pout !== seq_a[k]) mism = 1;
    end
    chk("R5 par_in ignored", {7'd0, mism}, 8'h00);
    scan_load(8'h00); set_mode(2'b01); pin = 8'hFF;
    step(); step(); step();
    chk("R6 zero lock", pout, 8'h00);
  endtask

  task automatic t_period();
    int  cnt;
    bit  zero_seen;
    scan_load(8'h01);
    set_mode(2'b01); cnt = 0; zero_seen = 0;
    do begin
      step(); cnt++;
      if (pout == '0) zero_seen = 1;
    end while (pout != 8'h01 && cnt < 300);
    chk("R7 period", 8'(cnt), 8'd255);
    chk("R7 no zero visited", {7'd0, zero_seen}, 8'h00);
  endtask

  task automatic t_compact();
    logic [W-1:0] exp_q, good;
    scan_load(8'h00);
    set_mode(2'b11); exp_q = '0;
    for (int k = 0; k < 10; k++) begin
      pin = 8'(k * 29 + 7); step();
      exp_q = model(2'b11, exp_q, pin, 1'b0);
    end
    chk("R8 signature", pout, exp_q);
    good = pout;
    scan_load(8'h00);
    set_mode(2'b11);
    for (int k = 0; k < 10; k++) begin
      pin = 8'(k * 29 + 7);
      if (k == 4) pin = pin ^ 8'h10;
      step();
    end
    n_chk++;
    if (pout === good) begin
      n_fail++;
      $display("FAIL R8 single-bit error hidden actual=%h expected!=%h", pout, good);
    end
  endtask

  task automatic t_mode_switch();
    logic [W-1:0] exp_q;
    scan_load(8'h81);
    set_mode(2'b10); pin = 8'h66; step();
    chk("R9 switch to load", pout, 8'h66);
    set_mode(2'b01); exp_q = model(2'b01, 8'h66, pin, 1'b0); step();
    chk("R9 switch to generator", pout, exp_q);
    set_mode(2'b11); pin = 8'h0F; exp_q = model(2'b11, exp_q, pin, 1'b0); step();
    chk("R9 switch to compactor", pout, exp_q);
    set_mode(2'b00); si = 1'b0; exp_q = model(2'b00, exp_q, pin, si); step();
    chk("R9 switch to shift", pout, exp_q);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_load();
    t_scan();
    t_gen();
    t_period();
    t_compact();
    t_mode_switch();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule